// File: doc/BRIEF.md
# Serial ADC Sample Capture Controller

This block fetches one conversion at a time from a serial analog-to-digital converter over a three-wire link: a serial clock, an active-low select and a data line. A requester raises `start`. The controller pulls the select low and, after one idle serial period, clocks a 16-bit frame out of the converter. It then releases the select, puts the 12-bit result on `sample` and raises `done`.

The serial clock is the 50 MHz system clock divided by four, which gives 12.5 MHz, well under the converter's 20 MHz limit. It is built from a phase counter that acts as a clock enable, so the whole block stays in one clock domain. The converter moves its data on falling serial clock edges, and the controller samples on the rising edges between them.

The sequencing is a three-state Moore machine with states Idle, ShiftIn and SyncData. A `start` held high produces exactly one conversion. The next conversion is armed only after `start` has been seen low.

Top module: `serial_adc_capture`

## Requirements
- R1: An active-low asynchronous reset immediately gives `done`=1, `cs_n`=1, `sclk`=1 and `sample`=0, and puts the machine in Idle.
- R2: A high `start` seen in Idle at a clock edge drives `cs_n` and `done` low directly after that edge.
- R3: During a conversion `done` equals `cs_n`, and both stay low for exactly SYS_DIV*(FRAME_BITS+1) = 68 system clocks. Exactly 16 falling and 16 rising `sclk` edges occur while `cs_n` is low.
- R4: `sclk` is high whenever `cs_n` is high. The first falling `sclk` edge comes at least 4 system clocks after `cs_n` falls.
- R5: During the bit transfer, every low phase and every high phase of `sclk` is 2 system clocks long (12.5 MHz at a 50 MHz system clock).
- R6: `sdi` is sampled on rising `sclk` edges, most significant bit first. `sample` equals bits 11..0 of the 16-bit frame, so bits 15..12 (normally zero) have no effect.
- R7: The controller raises `cs_n` and `done` and updates `sample` together, at the same clock edge.
- R8: While `start` stays high after a conversion, `cs_n` stays high and no new conversion begins. A new conversion starts only after `start` has been low for at least one clock.
- R9: `sample` holds its value between conversions.
- R10: A reset asserted in the middle of a transfer aborts it at once. A conversion requested afterwards completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, level sensitive |
| sdi | input | 1 | Serial data from the converter |
| sclk | output | 1 | Divided serial clock to the converter |
| cs_n | output | 1 | Active-low converter select |
| sample | output | 12 | Last captured 12-bit result |
| done | output | 1 | High when idle or finished, low while converting |

## Verification
The hardest case to reach from the ports is a `start` that stays high across the end of a frame. The risk there is that the machine re-enters ShiftIn without passing through Idle. The bench holds `start` for many cycles after `done` rises and checks that `cs_n` never drops and `sample` does not move. A second hard case is a reset that lands in the middle of a frame. The bench asserts reset partway through a transfer, checks the outputs without waiting for a clock edge, and then runs a fresh conversion. A converter model whose four leading frame bits are set shows that those bits never reach `sample`.

// File: rtl/adc_cap_pkg.sv
`timescale 1ns/1ps
package adc_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_SYNC  = 2'd2
  } cap_state_t;

  // System clocks with select low: one lead-in serial period plus one per frame bit.
  function automatic int unsigned frame_cycles(int unsigned div, int unsigned bits);
    return div * (bits + 1);
  endfunction
endpackage

// File: rtl/adc_cap_timing.sv
`timescale 1ns/1ps
module adc_cap_timing #(
  parameter int unsigned SYS_DIV    = 4,
  parameter int unsigned FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic sample_evt,
  output logic frame_end
);
  localparam int unsigned PH_W  = $clog2(SYS_DIV);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS);
  localparam int unsigned HALF  = SYS_DIV / 2;

  logic [PH_W-1:0]  ph;
  logic [CNT_W-1:0] bitc;
  logic             lead;
  logic             tick_end, last_bit;

  assign tick_end   = (ph == PH_W'(SYS_DIV - 1));
  assign last_bit   = (bitc == CNT_W'(FRAME_BITS - 1));
  assign sample_evt = run && !lead && (ph == PH_W'(HALF - 1));
  assign frame_end  = run && !lead && tick_end && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      bitc <= '0;
      lead <= 1'b1;
      sclk <= 1'b1;
    end else if (!run) begin
      ph   <= '0;
      bitc <= '0;
      lead <= 1'b1;
      sclk <= 1'b1;
    end else begin
      ph <= tick_end ? '0 : ph + 1'b1;
      if (tick_end) begin
        if (lead) begin
          lead <= 1'b0;
          sclk <= 1'b0;
        end else if (!last_bit) begin
          bitc <= bitc + 1'b1;
          sclk <= 1'b0;
        end
      end else if (sample_evt) begin
        sclk <= 1'b1;
      end
    end
  end

  // R6: a capture event is followed by the rising serial clock edge
  a_r6_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> $rose(sclk));

  // R4: clock stays high through the lead-in period
  a_r4_lead_high: assert property (@(posedge clk) disable iff (!rst_n)
    lead |-> sclk);

  generate
    if (HALF > 1) begin : g_low_check
      // R5: a low phase lasts more than one system clock
      a_r5_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |=> !sclk);
    end
  endgenerate
endmodule

// File: rtl/adc_cap_shifter.sv
`timescale 1ns/1ps
module adc_cap_shifter #(
  parameter int unsigned DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sdi,
  input  logic                 sample_evt,
  input  logic                 frame_end,
  output logic [DATA_BITS-1:0] sample
);
  // Only the last DATA_BITS serial bits are kept; earlier ones fall off the top.
  logic [DATA_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      sample <= '0;
    end else begin
      if (sample_evt) shreg <= {shreg[DATA_BITS-2:0], sdi};
      if (frame_end)  sample <= shreg;
    end
  end
endmodule

// File: rtl/adc_cap_fsm.sv
`timescale 1ns/1ps
module adc_cap_fsm
  import adc_cap_pkg::*;
#(
  parameter int unsigned SYS_DIV    = 4,
  parameter int unsigned FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic frame_end,
  output logic run,
  output logic cs_n,
  output logic done
);
  localparam int unsigned FRAME_CYC = frame_cycles(SYS_DIV, FRAME_BITS);
  localparam int unsigned CYC_W     = $clog2(FRAME_CYC + 1);

  cap_state_t       state, nxt;
  logic [CYC_W-1:0] shift_cyc;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start)     nxt = ST_SHIFT;
      ST_SHIFT: if (frame_end) nxt = ST_SYNC;
      ST_SYNC:  if (!start)    nxt = ST_IDLE;
      default:                 nxt = ST_IDLE;
    endcase
  end

  assign run = (state == ST_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      done      <= 1'b1;
      shift_cyc <= '0;
    end else begin
      state     <= nxt;
      cs_n      <= (nxt != ST_SHIFT);
      done      <= (nxt != ST_SHIFT);
      shift_cyc <= run ? shift_cyc + 1'b1 : '0;
    end
  end

  // R3: the frame closes after exactly the expected number of clocks
  a_r3_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (shift_cyc == CYC_W'(FRAME_CYC - 1)));

  // R8: a new select pulse only ever begins from Idle
  a_r8_launch_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(state) == ST_IDLE));
endmodule

// File: rtl/serial_adc_capture.sv
`timescale 1ns/1ps
module serial_adc_capture #(
  parameter int unsigned SYS_DIV    = 4,
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned DATA_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 sdi,
  output logic                 sclk,
  output logic                 cs_n,
  output logic [DATA_BITS-1:0] sample,
  output logic                 done
);
  logic run, sample_evt, frame_end;

  adc_cap_fsm #(.SYS_DIV(SYS_DIV), .FRAME_BITS(FRAME_BITS)) i_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_end(frame_end),
    .run(run), .cs_n(cs_n), .done(done)
  );

  adc_cap_timing #(.SYS_DIV(SYS_DIV), .FRAME_BITS(FRAME_BITS)) i_timing (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(sclk), .sample_evt(sample_evt), .frame_end(frame_end)
  );

  adc_cap_shifter #(.DATA_BITS(DATA_BITS)) i_shifter (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .sample_evt(sample_evt),
    .frame_end(frame_end), .sample(sample)
  );

  // R4: the serial clock idles high whenever the select is released
  a_r4_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R9: the result only moves at the edge where done rises
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample) |-> $rose(done));
endmodule

// File: tb/test_serial_adc_capture.sv
`timescale 1ns/1ps
module test_serial_adc_capture;
  localparam int unsigned DIV   = 4;
  localparam int unsigned FBITS = 16;
  localparam int unsigned DBITS = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdi = 1'b0;
  logic sclk, cs_n, done;
  logic [DBITS-1:0] sample;

  int errors = 0, checks = 0;

  serial_adc_capture #(.SYS_DIV(DIV), .FRAME_BITS(FBITS), .DATA_BITS(DBITS)) i_serial_adc_capture (
    .clk(clk), .rst_n(rst_n), .start(start), .sdi(sdi),
    .sclk(sclk), .cs_n(cs_n), .sample(sample), .done(done)
  );

  always #10 clk = ~clk;

  function automatic logic [11:0] exp_sample(logic [15:0] fr);
    return fr[11:0];
  endfunction
  function automatic int exp_low_clks();
    return DIV * (FBITS + 1);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Converter model: first bit after the first falling edge, then one per falling edge.
  logic [15:0] frame = '0;
  int idx = 15;
  always @(negedge cs_n) begin idx = 15; sdi <= 1'b0; end
  always @(negedge sclk) if (!cs_n && idx >= 0) begin sdi <= frame[idx]; idx--; end

  // Link monitors
  int falls = 0, rises = 0, width_bad = 0, mism = 0;
  realtime t_cs = 0, t_csr = 0, t_first = 0, t_last = 0;
  bit seen_first = 0;
  always @(negedge cs_n) begin
    falls = 0; rises = 0; width_bad = 0; seen_first = 0; t_cs = $realtime;
  end
  always @(posedge cs_n) t_csr = $realtime;
  always @(negedge sclk) if (!cs_n) begin
    if (!seen_first) begin seen_first = 1; t_first = $realtime; end
    else if (($realtime - t_last) != 20.0 * DIV / 2) width_bad++;
    falls++; t_last = $realtime;
  end
  always @(posedge sclk) if (!cs_n) begin
    if (($realtime - t_last) != 20.0 * DIV / 2) width_bad++;
    rises++; t_last = $realtime;
  end
  always @(negedge clk) if (rst_n && (done !== cs_n)) mism++;

  task automatic convert(logic [15:0] fr, bit short_pulse);
    int n;
    frame = fr;
    mism = 0;
    @(posedge clk); #1 start = 1'b1;
    @(negedge clk);
    check(cs_n === 1'b1, "R2 select before edge", cs_n, 1);
    if (short_pulse) begin @(posedge clk); #1 start = 1'b0; end
    @(negedge clk);
    check(cs_n === 1'b0 && done === 1'b0, "R2 launch", {cs_n, done}, 0);
    n = 0;
    while (done !== 1'b1 && n < 300) begin @(negedge clk); n++; end
    check(cs_n === 1'b1, "R7 select released with done", cs_n, 1);
    check(sample === exp_sample(fr), "R6 sample value", sample, exp_sample(fr));
    check(falls == FBITS && rises == FBITS, "R3 sclk edges", falls * 100 + rises, FBITS * 101);
    check(int'((t_csr - t_cs) / 20.0) == exp_low_clks(), "R3 select low clocks",
          int'((t_csr - t_cs) / 20.0), exp_low_clks());
    check(mism == 0, "R3 done equals select", mism, 0);
    check((t_first - t_cs) >= 20.0 * DIV, "R4 lead-in", int'((t_first - t_cs) / 20.0), DIV);
    check(width_bad == 0, "R5 phase widths", width_bad, 0);
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] held;
    bit hold_ok, idle_high;
    void'($urandom(32'h5EED));
    #35;
    check(done === 1'b1 && cs_n === 1'b1 && sclk === 1'b1, "R1 reset outputs", {done, cs_n, sclk}, 7);
    check(sample === 12'h000, "R1 reset sample", sample, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    convert(16'h0000, 0);
    convert(16'h0FFF, 0);
    convert(16'h0A55, 1);
    convert(16'h0800, 0);
    convert(16'h0001, 1);
    convert(16'hF123, 0);  // R6: nonzero leading bits must not reach the result
    for (int i = 0; i < 10; i++) convert({4'h0, 12'($urandom)}, i[0]);

    // R8 / R9: hold start well past the end of a frame
    frame = 16'h0C3A;
    @(posedge clk); #1 start = 1'b1;
    repeat (2) @(negedge clk);
    while (done !== 1'b1) @(negedge clk);
    held = sample;
    hold_ok = 1; idle_high = 1;
    repeat (60) begin
      @(negedge clk);
      if (cs_n !== 1'b1) hold_ok = 0;
      if (sclk !== 1'b1) idle_high = 0;
    end
    check(hold_ok, "R8 no retrigger while start held", hold_ok, 1);
    check(idle_high, "R4 sclk high while idle", idle_high, 1);
    check(sample === held && held === 12'hC3A, "R9 sample held", sample, 12'hC3A);
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    @(posedge clk); #1 start = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n === 1'b0, "R8 rearm after start low", cs_n, 0);
    while (done !== 1'b1) @(negedge clk);
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);

    // R10: reset partway through a transfer
    frame = 16'h0777;
    @(posedge clk); #1 start = 1'b1;
    repeat (30) @(negedge clk);
    check(cs_n === 1'b0, "R10 mid transfer", cs_n, 0);
    #3 rst_n = 1'b0;
    #2;
    check(cs_n === 1'b1 && done === 1'b1 && sclk === 1'b1, "R10 abort outputs", {cs_n, done, sclk}, 7);
    check(sample === 12'h000, "R1 async clear of sample", sample, 0);
    start = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    convert(16'h0396, 0);  // R10: recovery conversion

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule